// File: doc/BRIEF.md
# Serial Register Write Port

This block is the write side of a serial slave interface that feeds a bank of 128 eight-bit registers. The bus master pulls the active-low select line low and then clocks in a command byte. The leading bit of that byte tells the block whether the master wants to write or read. The seven bits after it give the starting register address. Each complete byte that follows is stored in a register. The first goes to the starting address, and the address moves up by one for every further byte, so a single transaction can fill a run of consecutive registers. When select goes high the transaction ends, however many bytes have been sent.

The serial clock, select and data pins are asynchronous to the system clock. The block passes them through flop synchronisers and acts on rising edges of the serial clock (mode 0). A mode input picks the wiring. In four-wire mode the dedicated input line carries the data. In three-wire mode the shared bidirectional line carries it, and the block never drives that line during a write. The serial output is never enabled either. The pad logic can read the contents of the bank at any time through a parallel read port.

Top module: `spi_wr_port`

## Requirements
- R1: After reset every register reads 0x00 on the parallel read port.
- R2: A frame begins with a command byte. Its first bit is the direction flag, where 0 means write, and it is followed by address bits A6..A0, most significant first. Each data byte after the command byte arrives most significant bit first.
- R3: A write frame of exactly 16 serial clocks stores its one data byte at the commanded address.
- R4: Each additional group of 8 serial clocks in a write frame stores one more byte, at an address one above the previous byte's address.
- R5: Address auto-increment wraps from 0x7F to 0x00.
- R6: A data byte that is still incomplete when select rises is discarded, and no register changes because of it.
- R7: A frame whose direction flag is 1 writes no register, whatever bits follow it.
- R8: A rising edge on select ends the frame. The next falling edge starts a new command byte, even if the earlier frame stopped partway through a byte.
- R9: The serial output enable `sdo_oe_o` stays low at all times in both modes, so the output is left in high impedance.
- R10: With `three_wire_i`=1, data is taken from `sdio_i` and `sdi_i` is ignored. With `three_wire_i`=0, data is taken from `sdi_i` and `sdio_i` is ignored. The framing is the same in both modes.
- R11: A stored byte appears on the read port no later than 4 system clock edges after the serial clock edge that carries its last bit reaches the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| three_wire_i | input | 1 | 1 selects three-wire mode, 0 selects four-wire mode |
| csn_i | input | 1 | Active-low select from the master |
| sclk_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Four-wire serial data input |
| sdio_i | input | 1 | Input side of the shared three-wire data line |
| sdo_o | output | 1 | Serial data output (never carries data) |
| sdo_oe_o | output | 1 | Output enable for the serial data line, held low |
| rd_addr_i | input | 7 | Parallel read port address |
| rd_data_o | output | 8 | Register contents at rd_addr_i |

## Verification
A serial clock edge on the pin takes two synchroniser stages to arrive. One more cycle is spent in the frame register and one in the bank write, so a stored byte shows up on the combinational read port after the fourth system clock edge. The bench drives every pin at the falling system clock edge and holds each half serial period for four system clocks, so data stays stable well around the synchronised edge. Most contents checks run after select has been released and settled. One check samples the read port exactly one time unit after the fourth rising edge that follows the final data-bit edge, which pins down the deadline in R11.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;
  localparam int unsigned SPI_AW = 7;
  localparam int unsigned SPI_DW = 8;
  localparam int unsigned SPI_NREGS = 1 << SPI_AW;
  localparam int unsigned SPI_CW = $clog2(SPI_DW);

  typedef enum logic {PH_CMD, PH_DATA} spi_phase_e;

  // next register address after a completed byte, wrapping at the top
  function automatic logic [SPI_AW-1:0] addr_next(input logic [SPI_AW-1:0] a);
    return a + 1'b1;
  endfunction

  // command byte: direction flag in the MSB, start address below it
  function automatic logic cmd_is_read(input logic [SPI_DW-1:0] c);
    return c[SPI_DW-1];
  endfunction

  function automatic logic [SPI_AW-1:0] cmd_addr(input logic [SPI_DW-1:0] c);
    return c[SPI_AW-1:0];
  endfunction
endpackage

// File: rtl/spi_wr_sync.sv
module spi_wr_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_wr_frame.sv
module spi_wr_frame
  import spi_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sd_s,
  output logic              wr_en_o,
  output logic [SPI_AW-1:0] wr_addr_o,
  output logic [SPI_DW-1:0] wr_data_o
);
  localparam logic [SPI_CW-1:0] BIT_LAST = SPI_CW'(SPI_DW - 1);

  logic              sclk_d;
  spi_phase_e        phase;
  logic [SPI_CW-1:0] bit_cnt;
  logic [SPI_DW-1:0] shreg;
  logic              rw_flag;
  logic [SPI_AW-1:0] cur_addr;

  // named internal events
  wire              sclk_rise = sclk_s & ~sclk_d;
  wire              bit_take  = sclk_rise & ~csn_s;
  wire              byte_done = bit_take & (bit_cnt == BIT_LAST);
  wire [SPI_DW-1:0] assembled = {shreg[SPI_DW-2:0], sd_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      phase     <= PH_CMD;
      bit_cnt   <= '0;
      shreg     <= '0;
      rw_flag   <= 1'b0;
      cur_addr  <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      sclk_d  <= sclk_s;
      wr_en_o <= 1'b0;
      if (csn_s) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
      end else if (bit_take) begin
        shreg   <= assembled;
        bit_cnt <= bit_cnt + 1'b1;
        if (byte_done) begin
          if (phase == PH_CMD) begin
            rw_flag  <= cmd_is_read(assembled);
            cur_addr <= cmd_addr(assembled);
            phase    <= PH_DATA;
          end else begin
            wr_en_o   <= ~rw_flag;
            wr_addr_o <= cur_addr;
            wr_data_o <= assembled;
            cur_addr  <= addr_next(cur_addr);
          end
        end
      end
    end
  end

  // R11: a write pulse is always one cycle behind a synchronised clock edge
  a_r11_wr_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(sclk_rise));
  // R7: read frames never produce a write pulse
  a_r7_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> !rw_flag);
  // R4/R5: the running address is one past the byte just written
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (cur_addr == addr_next(wr_addr_o)));
  // R8: select release returns the framer to a fresh command byte
  a_r8_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (phase == PH_CMD && bit_cnt == '0));
endmodule

// File: rtl/spi_wr_regfile.sv
module spi_wr_regfile
  import spi_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [SPI_AW-1:0] wr_addr_i,
  input  logic [SPI_DW-1:0] wr_data_i,
  input  logic [SPI_AW-1:0] rd_addr_i,
  output logic [SPI_DW-1:0] rd_data_o
);
  logic [SPI_DW-1:0] mem [SPI_NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SPI_NREGS; i++) mem[i] <= '0;
    end else if (wr_en_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i];

  // R3: a write request lands in the bank on the next edge
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mem[$past(wr_addr_i)] == $past(wr_data_i)));
endmodule

// File: rtl/spi_wr_port.sv
module spi_wr_port
  import spi_wr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              three_wire_i,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              sdio_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic [SPI_AW-1:0] rd_addr_i,
  output logic [SPI_DW-1:0] rd_data_o
);
  localparam int unsigned SYNC_W = 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = 3'b100;  // select idles high

  logic              sd_raw;
  logic              csn_s, sclk_s, sd_s;
  logic              wr_en;
  logic [SPI_AW-1:0] wr_addr;
  logic [SPI_DW-1:0] wr_data;

  // R10: mode picks which pin carries the serial data
  assign sd_raw = three_wire_i ? sdio_i : sdi_i;

  spi_wr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({csn_i, sclk_i, sd_raw}),
    .q_o   ({csn_s, sclk_s, sd_s})
  );

  spi_wr_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .csn_s     (csn_s),
    .sd_s      (sd_s),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  spi_wr_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  // R9: the serial output is never enabled by the write path
  assign sdo_o    = 1'b0;
  assign sdo_oe_o = 1'b0;
endmodule

// File: tb/sim_spi_wr_port.sv
module sim_spi_wr_port;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       three_wire = 1'b0;
  logic       csn = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       sdio = 1'b0;
  logic       sdo, sdo_oe;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct packed {logic [6:0] a; logic [7:0] d;} item_t;
  item_t      exp_q[$];
  logic       txq[$];
  logic [7:0] model [128];
  bit         oe_seen;

  always #2 clk = ~clk;  // 250 MHz

  spi_wr_port u0 (
    .clk(clk), .rst_n(rst_n), .three_wire_i(three_wire), .csn_i(csn),
    .sclk_i(sclk), .sdi_i(sdi), .sdio_i(sdio), .sdo_o(sdo),
    .sdo_oe_o(sdo_oe), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic half_period();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) txq.push_back(b[i]);
  endtask

  task automatic put_cmd(input logic rd, input logic [6:0] a);
    put_byte({rd, a}, 8);
  endtask

  // driver: plays txq on the selected data pin, junk on the other
  task automatic play(input int tcheck_bit, input logic [6:0] tcheck_addr,
                      input logic [7:0] tcheck_val);
    @(negedge clk);
    csn = 1'b0;
    half_period();
    for (int i = 0; i < txq.size(); i++) begin
      if (three_wire) begin sdio = txq[i]; sdi = ~txq[i]; end
      else            begin sdi = txq[i];  sdio = ~txq[i]; end
      half_period();
      sclk = 1'b1;
      if (sdo_oe) oe_seen = 1;
      if (i == tcheck_bit) begin
        rd_addr = tcheck_addr;
        repeat (4) @(posedge clk);
        #1;
        chk("R11 read port deadline", rd_data, tcheck_val);
        @(negedge clk);
      end else begin
        half_period();
      end
      sclk = 1'b0;
      if (sdo_oe) oe_seen = 1;
    end
    half_period();
    csn = 1'b1;
    repeat (8) @(negedge clk);
    txq.delete();
  endtask

  // monitor: pops expected writes and compares them on the read port
  task automatic drain(input string tag);
    while (exp_q.size() > 0) begin
      item_t it = exp_q.pop_front();
      model[it.a] = it.d;
      @(negedge clk);
      rd_addr = it.a;
      #1;
      chk(tag, rd_data, it.d);
    end
  endtask

  task automatic scan(input string tag);
    int nbad = 0;
    logic [7:0] fa = 0, fe = 0;
    logic [6:0] fx = 0;
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      rd_addr = 7'(a);
      #1;
      if (rd_data !== model[a]) begin
        if (nbad == 0) begin fa = rd_data; fe = model[a]; fx = 7'(a); end
        nbad++;
      end
    end
    total++;
    if (nbad != 0) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, fx, fa, fe);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    oe_seen = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    scan("R1 reset contents");
    chk("R9 oe low after reset", sdo_oe, 0);

    // R2 R3: single 16-clock write, with the R11 deadline on the last bit
    put_cmd(1'b0, 7'h15); put_byte(8'hA5, 8);
    exp_q.push_back({7'h15, 8'hA5});
    play(15, 7'h15, 8'hA5);
    drain("R3 single byte write");

    // R4: burst of four bytes
    put_cmd(1'b0, 7'h40);
    put_byte(8'h11, 8); put_byte(8'h22, 8); put_byte(8'h3C, 8); put_byte(8'hF0, 8);
    exp_q.push_back({7'h40, 8'h11}); exp_q.push_back({7'h41, 8'h22});
    exp_q.push_back({7'h42, 8'h3C}); exp_q.push_back({7'h43, 8'hF0});
    play(-1, 0, 0);
    drain("R4 burst auto increment");

    // R5: wrap from 0x7F to 0x00
    put_cmd(1'b0, 7'h7E);
    put_byte(8'h5A, 8); put_byte(8'h6B, 8); put_byte(8'h7C, 8);
    exp_q.push_back({7'h7E, 8'h5A}); exp_q.push_back({7'h7F, 8'h6B});
    exp_q.push_back({7'h00, 8'h7C});
    play(-1, 0, 0);
    drain("R5 address wrap");
    scan("R5 no stray writes");

    // R6: trailing partial byte dropped
    put_cmd(1'b0, 7'h10); put_byte(8'h99, 8); put_byte(8'hEE, 5);
    exp_q.push_back({7'h10, 8'h99});
    play(-1, 0, 0);
    drain("R6 full byte kept");
    scan("R6 partial byte discarded");

    // R7: read flag set, nothing written
    put_cmd(1'b1, 7'h20); put_byte(8'hC3, 8); put_byte(8'h3C, 8);
    play(-1, 0, 0);
    scan("R7 read frame writes nothing");

    // R8: frame aborted after 3 bits, then a clean frame
    put_byte(8'h00, 3);
    play(-1, 0, 0);
    scan("R8 aborted frame no effect");
    put_cmd(1'b0, 7'h33); put_byte(8'h81, 8);
    exp_q.push_back({7'h33, 8'h81});
    play(-1, 0, 0);
    drain("R8 new frame after release");

    // R10: three-wire mode, junk on sdi_i
    three_wire = 1'b1;
    put_cmd(1'b0, 7'h50); put_byte(8'hDE, 8); put_byte(8'hAD, 8);
    exp_q.push_back({7'h50, 8'hDE}); exp_q.push_back({7'h51, 8'hAD});
    play(-1, 0, 0);
    drain("R10 three-wire data path");
    chk("R9 oe low in three-wire", sdo_oe, 0);
    scan("R10 three-wire no stray writes");
    three_wire = 1'b0;
    put_cmd(1'b0, 7'h51); put_byte(8'h42, 8);
    exp_q.push_back({7'h51, 8'h42});
    play(-1, 0, 0);
    drain("R10 four-wire ignores sdio");

    chk("R9 oe never raised", oe_seen, 0);
    scan("R2 final contents");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule